// File: doc/BRIEF.md
# Controller Enable and Shutdown Handshake

This block is the register-side state machine for the configuration/status handshake of a queue-based storage controller. The host writes a 32-bit configuration word through a write strobe and data bus. The block stores the word at once. It then compares the new enable and shutdown-request fields with the previous configuration value. Only the transitions of those fields move the status word. The status word carries the ready flag, the fatal flag and the shutdown-progress code.

A rising enable starts the controller. The start succeeds and raises ready, or an external configuration checker reports a failure and the status collapses to the fatal flag alone. A falling enable performs a full controller reset. That reset clears the configuration word and the interrupt mask. It also loads the status word with a reset value that depends on the function type. A virtual function whose secondary controller is offline resets with the fatal flag set. A separate whole-function reset request performs the same clears. The block also emits one-cycle start and shutdown action pulses for the datapath.

Top module: `cfg_handshake`

## Requirements
- R1: While rst_n is low, cc_q, csts_q, int_mask_q, start_req_o and shdn_req_o are all zero.
- R2: A cc_wr_en write that does not lower the enable bit (bit 0) and is not accompanied by fn_reset_req appears in cc_q on the next cycle, all 32 bits.
- R3: A write that takes the shutdown field (bits 15:14) from zero to nonzero sets the status shutdown code (csts bits 3:2) to 2'b10 and pulses shdn_req_o for one cycle.
- R4: A write that takes the shutdown field from nonzero to zero clears csts bits 3:2. A change between two nonzero shutdown values leaves them unchanged.
- R5: A write that raises the enable bit while start_fail_i is low sets csts bit 0 (ready), keeps the other status bits and pulses start_req_o.
- R6: A write that raises the enable bit while start_fail_i is high makes csts exactly 32'h2 (fatal flag, bit 1, alone) and still pulses start_req_o.
- R7: A write that lowers the enable bit clears cc_q and int_mask_q and loads csts with the reset value. This overrides any shutdown code or mask write from the same cycle.
- R8: The status reset value is 32'h2 when is_virtual_i is high and sec_online_i is low, and zero otherwise.
- R9: fn_reset_req clears cc_q and int_mask_q and loads csts with the reset value. It has priority over a configuration or mask write in the same cycle and suppresses both pulses.
- R10: Within one write the shutdown transition is applied before the enable transition. A start failure therefore discards a shutdown code raised in the same write, while a successful start keeps it.
- R11: msk_set_wr ORs msk_data into int_mask_q and msk_clr_wr clears the msk_data bits. When both are high the clear wins.
- R12: A write that changes neither the enable level nor the zero/nonzero state of the shutdown field leaves csts unchanged.
- R13: The block never holds cc bit 0 high with csts ready low unless csts fatal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_wr_en | input | 1 | Configuration word write strobe |
| cc_wr_data | input | 32 | Configuration write data |
| start_fail_i | input | 1 | Start check failed, sampled on an enabling write |
| is_virtual_i | input | 1 | Function is a virtual function |
| sec_online_i | input | 1 | Secondary controller of the virtual function is online |
| fn_reset_req | input | 1 | Whole-function reset request |
| msk_set_wr | input | 1 | Interrupt mask set write |
| msk_clr_wr | input | 1 | Interrupt mask clear write |
| msk_data | input | 32 | Interrupt mask write data |
| cc_q | output | 32 | Current configuration word |
| csts_q | output | 32 | Current status word |
| int_mask_q | output | 32 | Current interrupt mask |
| start_req_o | output | 1 | One-cycle controller start pulse |
| shdn_req_o | output | 1 | One-cycle shutdown action pulse |

## Verification
The bench builds the block with its default field positions and with the virtual-function variant enabled. This makes the reset value depend on is_virtual_i and sec_online_i, so both the fatal and the clean reset values are in reach. Directed sequences cover these cases:
- configure then enable;
- enable with a forced start failure;
- disable together with a shutdown request;
- shutdown set, changed and cleared;
- combined shutdown and enable writes in both outcomes;
- virtual-function resets with the online flag low and high.

A long pseudo-random phase then mixes writes, mask updates, start failures and function resets against a behavioural model.

// File: rtl/cfg_handshake_pkg.sv
package cfg_handshake_pkg;

   // transitions detected on one configuration write
   typedef struct packed {
      logic en_rise;
      logic en_fall;
      logic shn_rise;
      logic shn_fall;
   } cc_edges_t;

   // builds a word of width w with only bit pos set
   function automatic logic [63:0] one_hot64(input int pos);
      logic [63:0] v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/cfg_handshake_edges.sv
module cfg_handshake_edges
   import cfg_handshake_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int EN_POS  = 0,
   parameter int SHN_LSB = 14,
   parameter int SHN_W   = 2
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] old_cc,
   input  logic [DATA_W-1:0] new_cc,
   output cc_edges_t         edges
);

   logic old_shn_act;
   logic new_shn_act;

   assign old_shn_act = |old_cc[SHN_LSB +: SHN_W];
   assign new_shn_act = |new_cc[SHN_LSB +: SHN_W];

   always_comb begin
      edges          = '0;
      edges.en_rise  = wr_en &&  new_cc[EN_POS] && !old_cc[EN_POS];
      edges.en_fall  = wr_en && !new_cc[EN_POS] &&  old_cc[EN_POS];
      edges.shn_rise = wr_en &&  new_shn_act && !old_shn_act;
      edges.shn_fall = wr_en && !new_shn_act &&  old_shn_act;
   end

endmodule

// File: rtl/cfg_handshake_rstval.sv
module cfg_handshake_rstval #(
   parameter int DATA_W     = 32,
   parameter int CFS_POS    = 1,
   parameter bit VF_CAPABLE = 1'b1
) (
   input  logic              is_virtual_i,
   input  logic              sec_online_i,
   output logic [DATA_W-1:0] rst_val
);

   localparam logic [DATA_W-1:0] FATAL_ONLY = DATA_W'(1) << CFS_POS;

   generate
      if (VF_CAPABLE) begin : g_vf
         assign rst_val = (is_virtual_i && !sec_online_i) ? FATAL_ONLY : '0;
      end else begin : g_pf
         logic unused_in;
         assign unused_in = is_virtual_i ^ sec_online_i;
         assign rst_val   = unused_in ? '0 : '0;
      end
   endgenerate

endmodule

// File: rtl/cfg_handshake_status.sv
module cfg_handshake_status
   import cfg_handshake_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int RDY_POS   = 0,
   parameter int CFS_POS   = 1,
   parameter int SHST_LSB  = 2,
   parameter int SHST_W    = 2,
   parameter int SHST_DONE = 2
) (
   input  logic [DATA_W-1:0] csts_cur,
   input  cc_edges_t         edges,
   input  logic              start_fail_i,
   input  logic [DATA_W-1:0] rst_val,
   output logic [DATA_W-1:0] csts_nxt
);

   localparam logic [DATA_W-1:0] FATAL_ONLY = DATA_W'(1) << CFS_POS;
   localparam logic [SHST_W-1:0] SH_DONE    = SHST_W'(SHST_DONE);

   always_comb begin
      csts_nxt = csts_cur;
      // shutdown transitions first
      if (edges.shn_rise) begin
         csts_nxt[SHST_LSB +: SHST_W] = '0;
         csts_nxt[SHST_LSB +: SHST_W] = SH_DONE;
      end else if (edges.shn_fall) begin
         csts_nxt[SHST_LSB +: SHST_W] = '0;
      end
      // enable transitions second; a disable replaces everything
      if (edges.en_rise) begin
         if (start_fail_i) begin
            csts_nxt = FATAL_ONLY;
         end else begin
            csts_nxt[RDY_POS] = 1'b1;
         end
      end else if (edges.en_fall) begin
         csts_nxt = rst_val;
      end
   end

endmodule

// File: rtl/cfg_handshake_mask.sv
module cfg_handshake_mask #(
   parameter int MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic [MASK_W-1:0] data,
   output logic [MASK_W-1:0] mask_q
);

   logic [MASK_W-1:0] after_set;
   logic [MASK_W-1:0] mask_d;

   always_comb begin
      after_set = set_wr ? (mask_q | data) : mask_q;
      mask_d    = clr_wr ? (after_set & ~data) : after_set;
      if (clear) begin
         mask_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else begin
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/cfg_handshake.sv
module cfg_handshake
   import cfg_handshake_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MASK_W     = 32,
   parameter int EN_POS     = 0,
   parameter int SHN_LSB    = 14,
   parameter int SHN_W      = 2,
   parameter int RDY_POS    = 0,
   parameter int CFS_POS    = 1,
   parameter int SHST_LSB   = 2,
   parameter int SHST_W     = 2,
   parameter int SHST_DONE  = 2,
   parameter bit VF_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cc_wr_en,
   input  logic [DATA_W-1:0] cc_wr_data,
   input  logic              start_fail_i,
   input  logic              is_virtual_i,
   input  logic              sec_online_i,
   input  logic              fn_reset_req,
   input  logic              msk_set_wr,
   input  logic              msk_clr_wr,
   input  logic [MASK_W-1:0] msk_data,
   output logic [DATA_W-1:0] cc_q,
   output logic [DATA_W-1:0] csts_q,
   output logic [MASK_W-1:0] int_mask_q,
   output logic              start_req_o,
   output logic              shdn_req_o
);

   localparam int SHN_MSB  = SHN_LSB + SHN_W - 1;
   localparam int SHST_MSB = SHST_LSB + SHST_W - 1;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8 || DATA_W > 64) begin : g_bad_width
         $error("cfg_handshake: DATA_W out of range");
      end
      if (SHN_MSB >= DATA_W || EN_POS >= DATA_W) begin : g_bad_cc
         $error("cfg_handshake: configuration field outside word");
      end
      if (SHST_MSB >= DATA_W || RDY_POS >= DATA_W || CFS_POS >= DATA_W) begin : g_bad_st
         $error("cfg_handshake: status field outside word");
      end
      if (RDY_POS == CFS_POS) begin : g_bad_overlap
         $error("cfg_handshake: ready and fatal share a bit");
      end
      if (SHST_DONE == 0 || SHST_DONE >= (1 << SHST_W)) begin : g_bad_code
         $error("cfg_handshake: shutdown-complete code invalid");
      end
   endgenerate

   cc_edges_t         edges;
   logic [DATA_W-1:0] rst_val;
   logic [DATA_W-1:0] csts_nxt;
   logic              ctrl_reset;

   cfg_handshake_edges #(
      .DATA_W (DATA_W),
      .EN_POS (EN_POS),
      .SHN_LSB(SHN_LSB),
      .SHN_W  (SHN_W)
   ) u_edges (
      .wr_en (cc_wr_en),
      .old_cc(cc_q),
      .new_cc(cc_wr_data),
      .edges (edges)
   );

   cfg_handshake_rstval #(
      .DATA_W    (DATA_W),
      .CFS_POS   (CFS_POS),
      .VF_CAPABLE(VF_CAPABLE)
   ) u_rstval (
      .is_virtual_i(is_virtual_i),
      .sec_online_i(sec_online_i),
      .rst_val     (rst_val)
   );

   cfg_handshake_status #(
      .DATA_W   (DATA_W),
      .RDY_POS  (RDY_POS),
      .CFS_POS  (CFS_POS),
      .SHST_LSB (SHST_LSB),
      .SHST_W   (SHST_W),
      .SHST_DONE(SHST_DONE)
   ) u_status (
      .csts_cur    (csts_q),
      .edges       (edges),
      .start_fail_i(start_fail_i),
      .rst_val     (rst_val),
      .csts_nxt    (csts_nxt)
   );

   // any reset kind clears mask and configuration
   assign ctrl_reset = fn_reset_req || edges.en_fall;

   cfg_handshake_mask #(
      .MASK_W(MASK_W)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ctrl_reset),
      .set_wr(msk_set_wr),
      .clr_wr(msk_clr_wr),
      .data  (msk_data),
      .mask_q(int_mask_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_q        <= '0;
         csts_q      <= '0;
         start_req_o <= 1'b0;
         shdn_req_o  <= 1'b0;
      end else if (fn_reset_req) begin
         cc_q        <= '0;
         csts_q      <= rst_val;
         start_req_o <= 1'b0;
         shdn_req_o  <= 1'b0;
      end else begin
         start_req_o <= edges.en_rise;
         shdn_req_o  <= edges.shn_rise;
         if (cc_wr_en) begin
            cc_q   <= edges.en_fall ? '0 : cc_wr_data;
            csts_q <= csts_nxt;
         end
      end
   end

endmodule

// File: rtl/cfg_handshake_chk.sv
module cfg_handshake_chk #(
   parameter int DATA_W     = 32,
   parameter int MASK_W     = 32,
   parameter int EN_POS     = 0,
   parameter int SHN_LSB    = 14,
   parameter int SHN_W      = 2,
   parameter int RDY_POS    = 0,
   parameter int CFS_POS    = 1,
   parameter int SHST_LSB   = 2,
   parameter int SHST_W     = 2,
   parameter int SHST_DONE  = 2,
   parameter bit VF_CAPABLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cc_wr_en,
   input logic [DATA_W-1:0] cc_wr_data,
   input logic              start_fail_i,
   input logic              is_virtual_i,
   input logic              sec_online_i,
   input logic              fn_reset_req,
   input logic              msk_set_wr,
   input logic              msk_clr_wr,
   input logic [MASK_W-1:0] msk_data,
   input logic [DATA_W-1:0] cc_q,
   input logic [DATA_W-1:0] csts_q,
   input logic [MASK_W-1:0] int_mask_q,
   input logic              start_req_o,
   input logic              shdn_req_o
);

   localparam logic [DATA_W-1:0] FATAL_ONLY = DATA_W'(1) << CFS_POS;

   logic              wr_ok;
   logic              new_shn;
   logic              old_shn;
   logic              up;
   logic              down;
   logic [DATA_W-1:0] exp_rst;
   logic              unused_set;

   assign wr_ok      = cc_wr_en && !fn_reset_req;
   assign new_shn    = |cc_wr_data[SHN_LSB +: SHN_W];
   assign old_shn    = |cc_q[SHN_LSB +: SHN_W];
   assign up         = wr_ok &&  cc_wr_data[EN_POS] && !cc_q[EN_POS];
   assign down       = wr_ok && !cc_wr_data[EN_POS] &&  cc_q[EN_POS];
   assign exp_rst    = (VF_CAPABLE && is_virtual_i && !sec_online_i) ? FATAL_ONLY : '0;
   assign unused_set = msk_set_wr;

   // R2
   cc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && !down |=> cc_q == $past(cc_wr_data));

   // R3
   shn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && new_shn && !old_shn && (cc_wr_data[EN_POS] == cc_q[EN_POS])
      |=> csts_q[SHST_LSB +: SHST_W] == SHST_W'(SHST_DONE) && shdn_req_o);

   // R4
   shn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && !new_shn && old_shn && (cc_wr_data[EN_POS] == cc_q[EN_POS])
      |=> csts_q[SHST_LSB +: SHST_W] == '0);

   // R5
   start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up && !start_fail_i |=> csts_q[RDY_POS] && start_req_o);

   // R6
   start_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up && start_fail_i |=> csts_q == FATAL_ONLY);

   // R7
   disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      down |=> cc_q == '0 && int_mask_q == '0 && csts_q == $past(exp_rst));

   // R9
   fn_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fn_reset_req |=> cc_q == '0 && int_mask_q == '0 && csts_q == $past(exp_rst)
                       && !start_req_o && !shdn_req_o);

   // R11
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msk_clr_wr |=> (int_mask_q & $past(msk_data)) == '0);

   // R12
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok && (cc_wr_data[EN_POS] == cc_q[EN_POS]) && (new_shn == old_shn)
      |=> $stable(csts_q));

   // R13
   no_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cc_q[EN_POS] && !csts_q[RDY_POS] |-> csts_q[CFS_POS]);

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_state_chk: assert (unused_set || (cc_q == '0 && int_mask_q == '0));
      end
   end

endmodule

bind cfg_handshake cfg_handshake_chk #(
   .DATA_W    (DATA_W),
   .MASK_W    (MASK_W),
   .EN_POS    (EN_POS),
   .SHN_LSB   (SHN_LSB),
   .SHN_W     (SHN_W),
   .RDY_POS   (RDY_POS),
   .CFS_POS   (CFS_POS),
   .SHST_LSB  (SHST_LSB),
   .SHST_W    (SHST_W),
   .SHST_DONE (SHST_DONE),
   .VF_CAPABLE(VF_CAPABLE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cc_wr_en    (cc_wr_en),
   .cc_wr_data  (cc_wr_data),
   .start_fail_i(start_fail_i),
   .is_virtual_i(is_virtual_i),
   .sec_online_i(sec_online_i),
   .fn_reset_req(fn_reset_req),
   .msk_set_wr  (msk_set_wr),
   .msk_clr_wr  (msk_clr_wr),
   .msk_data    (msk_data),
   .cc_q        (cc_q),
   .csts_q      (csts_q),
   .int_mask_q  (int_mask_q),
   .start_req_o (start_req_o),
   .shdn_req_o  (shdn_req_o)
);

// File: tb/test_cfg_handshake.sv
`timescale 1ns/1ps
module test_cfg_handshake;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cc_wr_en = 1'b0;
   logic [31:0] cc_wr_data = '0;
   logic        start_fail_i = 1'b0;
   logic        is_virtual_i = 1'b0;
   logic        sec_online_i = 1'b0;
   logic        fn_reset_req = 1'b0;
   logic        msk_set_wr = 1'b0;
   logic        msk_clr_wr = 1'b0;
   logic [31:0] msk_data = '0;
   logic [31:0] cc_q;
   logic [31:0] csts_q;
   logic [31:0] int_mask_q;
   logic        start_req_o;
   logic        shdn_req_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   cfg_handshake i_cfg_handshake (
      .clk(clk), .rst_n(rst_n), .cc_wr_en(cc_wr_en), .cc_wr_data(cc_wr_data),
      .start_fail_i(start_fail_i), .is_virtual_i(is_virtual_i),
      .sec_online_i(sec_online_i), .fn_reset_req(fn_reset_req),
      .msk_set_wr(msk_set_wr), .msk_clr_wr(msk_clr_wr), .msk_data(msk_data),
      .cc_q(cc_q), .csts_q(csts_q), .int_mask_q(int_mask_q),
      .start_req_o(start_req_o), .shdn_req_o(shdn_req_o)
   );

   // behavioural reference model
   logic [31:0] m_cc, m_csts, m_mask;
   bit          m_st, m_sd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cc = 0; m_csts = 0; m_mask = 0; m_st = 0; m_sd = 0;
      end else begin
         logic [31:0] rv;
         rv = (is_virtual_i && !sec_online_i) ? 32'h2 : 32'h0;
         m_st = 0; m_sd = 0;
         if (fn_reset_req) begin
            m_cc = 0; m_csts = rv; m_mask = 0;
         end else begin
            if (msk_set_wr) m_mask = m_mask | msk_data;
            if (msk_clr_wr) m_mask = m_mask & ~msk_data;
            if (cc_wr_en) begin
               bit was_en, was_sd, is_en, is_sd;
               was_en = m_cc[0]; was_sd = (m_cc[15:14] != 0);
               is_en = cc_wr_data[0]; is_sd = (cc_wr_data[15:14] != 0);
               m_cc = cc_wr_data;
               if (is_sd && !was_sd) begin
                  m_csts[3:2] = 2'b10; m_sd = 1;
               end else if (!is_sd && was_sd) begin
                  m_csts[3:2] = 2'b00;
               end
               if (is_en && !was_en) begin
                  m_st = 1;
                  if (start_fail_i) m_csts = 32'h2;
                  else m_csts[0] = 1'b1;
               end else if (!is_en && was_en) begin
                  m_cc = 0; m_mask = 0; m_csts = rv;
               end
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 model cc", cc_q, m_cc);
         chk("R5 model csts", csts_q, m_csts);
         chk("R11 model mask", int_mask_q, m_mask);
         chk("R5 model start pulse", {31'd0, start_req_o}, {31'd0, m_st});
         chk("R3 model shutdown pulse", {31'd0, shdn_req_o}, {31'd0, m_sd});
         chk("R13 ready invariant",
             {31'd0, (cc_q[0] && !csts_q[0] && !csts_q[1])}, 32'd0);
      end
   end

   task automatic wr_cc(input logic [31:0] d);
      @(negedge clk);
      cc_wr_en = 1; cc_wr_data = d;
      @(negedge clk);
      cc_wr_en = 0;
   endtask

   task automatic wr_mask(input bit s, input bit c, input logic [31:0] d);
      @(negedge clk);
      msk_set_wr = s; msk_clr_wr = c; msk_data = d;
      @(negedge clk);
      msk_set_wr = 0; msk_clr_wr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset cc", cc_q, 0);
      chk("R1 reset csts", csts_q, 0);
      chk("R1 reset mask", int_mask_q, 0);
      rst_n = 1;

      wr_cc(32'h0046_0000);
      chk("R2 configure stored", cc_q, 32'h0046_0000);
      chk("R12 configure no status", csts_q, 0);
      wr_cc(32'h0046_0001);
      chk("R5 enable ready", csts_q, 32'h1);
      chk("R5 start pulse", {31'd0, start_req_o}, 1);

      wr_mask(1, 0, 32'hF1);
      wr_mask(0, 1, 32'h31);
      chk("R11 set then clear", int_mask_q, 32'hC0);
      wr_mask(1, 1, 32'h1);
      chk("R11 clear wins", int_mask_q, 32'hC0);

      wr_cc(32'h0046_4001);
      chk("R3 shutdown complete", csts_q, 32'h9);
      chk("R3 shutdown pulse", {31'd0, shdn_req_o}, 1);
      wr_cc(32'h0046_8001);
      chk("R4 nonzero change holds", csts_q, 32'h9);
      wr_cc(32'h0046_0001);
      chk("R4 shutdown cleared", csts_q, 32'h1);

      wr_cc(32'h0046_4000);
      chk("R7 disable csts", csts_q, 0);
      chk("R7 disable cc", cc_q, 0);
      chk("R7 disable mask", int_mask_q, 0);

      start_fail_i = 1;
      wr_cc(32'h1);
      chk("R6 start failure", csts_q, 32'h2);
      wr_cc(32'h1);
      chk("R12 level write holds", csts_q, 32'h2);
      start_fail_i = 0;

      is_virtual_i = 1; sec_online_i = 0;
      wr_cc(32'h0);
      chk("R8 vf offline reset", csts_q, 32'h2);
      sec_online_i = 1;
      wr_cc(32'h1);
      chk("R5 start keeps fatal", csts_q, 32'h3);
      wr_cc(32'h0);
      chk("R8 vf online reset", csts_q, 0);
      is_virtual_i = 0; sec_online_i = 0;
      wr_cc(32'h1);
      wr_cc(32'h0);
      chk("R8 pf reset", csts_q, 0);

      start_fail_i = 1;
      wr_cc(32'h4001);
      chk("R10 fail drops shutdown", csts_q, 32'h2);
      start_fail_i = 0;
      wr_cc(32'h0);
      wr_cc(32'h4001);
      chk("R10 success keeps shutdown", csts_q, 32'h9);

      wr_mask(1, 0, 32'hFF);
      is_virtual_i = 1; sec_online_i = 0;
      @(negedge clk);
      fn_reset_req = 1; cc_wr_en = 1; cc_wr_data = 32'h0; msk_set_wr = 1; msk_data = 32'h5;
      @(negedge clk);
      fn_reset_req = 0; cc_wr_en = 0; msk_set_wr = 0;
      chk("R9 fn reset cc", cc_q, 0);
      chk("R9 fn reset mask", int_mask_q, 0);
      chk("R9 fn reset csts", csts_q, 32'h2);

      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         cc_wr_en     = ($urandom % 2) == 0;
         cc_wr_data   = {$urandom} & 32'h0000_C0F1;
         start_fail_i = ($urandom % 4) == 0;
         is_virtual_i = ($urandom % 2) == 0;
         sec_online_i = ($urandom % 2) == 0;
         fn_reset_req = ($urandom % 40) == 0;
         msk_set_wr   = ($urandom % 5) == 0;
         msk_clr_wr   = ($urandom % 5) == 0;
         msk_data     = $urandom;
      end
      @(negedge clk);
      cc_wr_en = 0; fn_reset_req = 0; msk_set_wr = 0; msk_clr_wr = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule